// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Aligner

This block sits between a 32-bit instruction memory port and an instruction decoder. Memory hands it naturally aligned 32-bit words; the block cuts that word stream into whole instructions of 16 or 32 bits. It tells the decoder which kind each one is, how far the PC moves past it, and the PC at which it starts. A leftover 16-bit half is kept in a holding register. Instructions may start on any half-word boundary, so a 32-bit instruction can straddle two fetch words. In that case the block joins the held upper half of one word with the lower half of the next, and keeps the upper half of that next word for later.

Both data interfaces use valid/ready. On the fetch side the block drives `fetch_addr_o` (always word aligned) and `fetch_ready_o`. The memory answers with `fetch_valid_i` and `fetch_data_i`, which must hold the word at `fetch_addr_o` during that cycle. A word is taken on a rising edge where both valid and ready are high. On the issue side `inst_valid_o` stays high, with all issue outputs held still, until the decoder raises `inst_ready_i`. While the issue register holds an instruction that has not been taken, no word is fetched. `fetch_ready_o` depends combinationally on `inst_ready_i`. A flush (`flush_i` with `flush_pc_i`) discards the holding register, any pending instruction (even if `inst_ready_i` is high in that cycle) and any halt, and restarts at the new PC. A compressed half-word of all zeros is illegal. The block raises `illegal_o` in its place and then stops until the next flush.

Top module: `fetch_aligner`

## Requirements
- R1: An instruction whose lowest half-word has bits [1:0] equal to 2'b11 is 32 bits: `inst_compressed_o`=0 and `inst_len_o`=4. Any other value there makes it compressed: `inst_compressed_o`=1, `inst_len_o`=2, and `inst_o[31:16]`=0 with the half in `inst_o[15:0]`.
- R2: A compressed instruction in the low half of a fresh word is issued first. The upper half of that word is issued or combined next, with no further fetch needed for it.
- R3: A 32-bit instruction that starts at a word-aligned PC is issued as the whole fetched word, and nothing is left held.
- R4: A 32-bit instruction whose low half is held is issued as {low half of the next fetched word, held half}. The upper half of that next word becomes the new held half.
- R5: `inst_pc_o` is the byte address of the issued instruction. Each following instruction's PC is the previous one plus its length.
- R6: `fetch_addr_o` is word aligned, and each word is fetched exactly once. A run from start PC s that ends at half-word address e takes (e>>2)-(s>>2)+1 fetches.
- R7: A compressed half of 16'h0000, even one held as the upper half of an earlier word, is not issued. `illegal_o` rises, and `fetch_ready_o` and `inst_valid_o` stay low until a flush.
- R8: A flush clears the held half, the pending instruction and `illegal_o`, and restarts at `flush_pc_i`. When bit 1 of that PC is set, the low half of the first word is discarded.
- R9: While `inst_valid_o` is high and `inst_ready_i` is low, the issue outputs stay stable and `fetch_ready_o` is low.
- R10: After reset no instruction is valid, `illegal_o` is low, and `fetch_addr_o` equals the word holding the reset PC (0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard all state and restart at `flush_pc_i` |
| flush_pc_i | input | ADDR_W | Restart PC (half-word aligned) |
| fetch_addr_o | output | ADDR_W | Word-aligned address of the word wanted |
| fetch_ready_o | output | 1 | Block can take a fetch word this cycle |
| fetch_valid_i | input | 1 | `fetch_data_i` holds the word at `fetch_addr_o` |
| fetch_data_i | input | 32 | Fetched word |
| inst_valid_o | output | 1 | An instruction is presented |
| inst_ready_i | input | 1 | Decoder takes the presented instruction |
| inst_o | output | 32 | Instruction, compressed ones zero-extended |
| inst_pc_o | output | ADDR_W | PC of the presented instruction |
| inst_compressed_o | output | 1 | Presented instruction is 16 bits |
| inst_len_o | output | 3 | PC increment, 2 or 4 |
| illegal_o | output | 1 | All-zero compressed half met; fetch halted |

## Verification
A wrong held-half valid bit shows at the next issue. The decoder either receives a stale half joined into a 32-bit word, or a word is fetched again, and both show in that same instruction and in the fetch count of the run. A word address that steps wrongly puts a foreign upper half into the next straddling instruction. A skip flag left stale after a flush corrupts the very first instruction after that flush. A PC that steps wrongly shows on the next handshake, because every issued PC is compared with the one expected from the program.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int HALF_W = 16;
  localparam int ILEN   = 32;
  localparam int LEN_W  = 3;

  typedef logic [HALF_W-1:0] half_t;

  // Candidate instruction produced by the classifier
  typedef struct packed {
    logic [ILEN-1:0] inst;
    logic            cmp;
  } cand_t;

  // A half-word opens a full-width instruction when its two low bits are set
  function automatic logic is_full(half_t h);
    return h[1:0] == 2'b11;
  endfunction

  function automatic logic [LEN_W-1:0] len_of(logic cmp);
    return cmp ? LEN_W'(2) : LEN_W'(4);
  endfunction
endpackage

// File: rtl/fa_classify.sv
module fa_classify
  import fa_pkg::*;
(
  input  logic            hold_v_i,
  input  half_t           hold_i,
  input  logic            skip_i,
  input  logic            word_v_i,
  input  logic [ILEN-1:0] word_i,
  output logic            need_word_o,
  output logic            act_o,
  output logic            emit_o,
  output cand_t           cand_o,
  output half_t           nxt_hold_o,
  output logic            nxt_hold_v_o
);
  half_t lo_half, hi_half;
  assign lo_half = word_i[HALF_W-1:0];
  assign hi_half = word_i[ILEN-1:HALF_W];

  always_comb begin
    need_word_o  = 1'b1;
    act_o        = 1'b0;
    emit_o       = 1'b0;
    cand_o       = '0;
    nxt_hold_o   = hold_i;
    nxt_hold_v_o = hold_v_i;
    if (hold_v_i && !is_full(hold_i)) begin
      // held compressed half: issue without touching memory
      need_word_o  = 1'b0;
      act_o        = 1'b1;
      emit_o       = 1'b1;
      cand_o.inst  = {{HALF_W{1'b0}}, hold_i};
      cand_o.cmp   = 1'b1;
      nxt_hold_v_o = 1'b0;
    end else if (hold_v_i) begin
      // straddling full-width instruction
      act_o        = word_v_i;
      emit_o       = word_v_i;
      cand_o.inst  = {lo_half, hold_i};
      cand_o.cmp   = 1'b0;
      nxt_hold_o   = hi_half;
      nxt_hold_v_o = 1'b1;
    end else begin
      act_o      = word_v_i;
      nxt_hold_o = hi_half;
      if (skip_i) begin
        // restart on an odd half: drop the low half
        nxt_hold_v_o = 1'b1;
      end else if (!is_full(lo_half)) begin
        emit_o       = word_v_i;
        cand_o.inst  = {{HALF_W{1'b0}}, lo_half};
        cand_o.cmp   = 1'b1;
        nxt_hold_v_o = 1'b1;
      end else begin
        emit_o       = word_v_i;
        cand_o.inst  = word_i;
        cand_o.cmp   = 1'b0;
        nxt_hold_v_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fa_holdreg.sv
module fa_holdreg
  import fa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_i,
  input  logic  load_i,
  input  half_t d_i,
  input  logic  dv_i,
  output half_t q_o,
  output logic  v_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
      v_o <= 1'b0;
    end else if (clr_i) begin
      q_o <= '0;
      v_o <= 1'b0;
    end else if (load_i) begin
      q_o <= d_i;
      v_o <= dv_i;
    end
  end
endmodule

// File: rtl/fa_seq.sv
module fa_seq
  import fa_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_pc_i,
  input  logic              used_word_i,
  input  logic              issue_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              bad_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              skip_o,
  output logic              halted_o
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] widx_q;

  assign waddr_o = {widx_q, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o     <= RESET_PC;
      widx_q   <= RESET_PC[ADDR_W-1:2];
      skip_o   <= RESET_PC[1];
      halted_o <= 1'b0;
    end else if (flush_i) begin
      pc_o     <= flush_pc_i;
      widx_q   <= flush_pc_i[ADDR_W-1:2];
      skip_o   <= flush_pc_i[1];
      halted_o <= 1'b0;
    end else begin
      if (used_word_i) begin
        widx_q <= widx_q + WA_W'(1);
        skip_o <= 1'b0;
      end
      if (issue_i) pc_o <= pc_o + ADDR_W'(len_i);
      if (bad_i) halted_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fa_outstage.sv
module fa_outstage
  import fa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              load_i,
  input  cand_t             cand_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ILEN-1:0]   inst_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              cmp_o,
  output logic [LEN_W-1:0]  len_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      inst_o  <= '0;
      pc_o    <= '0;
      cmp_o   <= 1'b0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      inst_o  <= cand_i.inst;
      pc_o    <= pc_i;
      cmp_o   <= cand_i.cmp;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign len_o = len_of(cmp_o);
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_pc_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_ready_o,
  input  logic              fetch_valid_i,
  input  logic [ILEN-1:0]   fetch_data_i,
  output logic              inst_valid_o,
  input  logic              inst_ready_i,
  output logic [ILEN-1:0]   inst_o,
  output logic [ADDR_W-1:0] inst_pc_o,
  output logic              inst_compressed_o,
  output logic [LEN_W-1:0]  inst_len_o,
  output logic              illegal_o
);
  half_t       hold_q, nxt_hold;
  logic        hold_v, nxt_hold_v;
  logic        need_word, act, emit;
  cand_t       cand;
  logic        skip, halted;
  logic [ADDR_W-1:0] pc_q;
  logic        out_free, adv, fire, bad, issue;

  assign out_free      = !inst_valid_o || inst_ready_i;
  assign adv           = out_free && !halted && !flush_i;
  assign fetch_ready_o = adv && need_word;
  assign fire          = adv && act;
  assign bad           = fire && emit && cand.cmp && (cand.inst[HALF_W-1:0] == '0);
  assign issue         = fire && emit && !bad;
  assign illegal_o     = halted;

  fa_classify u_cls (
    .hold_v_i    (hold_v),
    .hold_i      (hold_q),
    .skip_i      (skip),
    .word_v_i    (fetch_valid_i),
    .word_i      (fetch_data_i),
    .need_word_o (need_word),
    .act_o       (act),
    .emit_o      (emit),
    .cand_o      (cand),
    .nxt_hold_o  (nxt_hold),
    .nxt_hold_v_o(nxt_hold_v)
  );

  fa_holdreg u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (flush_i),
    .load_i(fire),
    .d_i   (nxt_hold),
    .dv_i  (nxt_hold_v),
    .q_o   (hold_q),
    .v_o   (hold_v)
  );

  fa_seq #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .flush_pc_i (flush_pc_i),
    .used_word_i(fire && need_word),
    .issue_i    (issue),
    .len_i      (len_of(cand.cmp)),
    .bad_i      (bad),
    .pc_o       (pc_q),
    .waddr_o    (fetch_addr_o),
    .skip_o     (skip),
    .halted_o   (halted)
  );

  fa_outstage #(.ADDR_W(ADDR_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush_i(flush_i),
    .load_i (issue),
    .cand_i (cand),
    .pc_i   (pc_q),
    .ready_i(inst_ready_i),
    .valid_o(inst_valid_o),
    .inst_o (inst_o),
    .pc_o   (inst_pc_o),
    .cmp_o  (inst_compressed_o),
    .len_o  (inst_len_o)
  );
endmodule

// File: rtl/fa_checker.sv
module fa_checker
  import fa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_ready_o,
  input logic              inst_valid_o,
  input logic              inst_ready_i,
  input logic [ILEN-1:0]   inst_o,
  input logic [ADDR_W-1:0] inst_pc_o,
  input logic              inst_compressed_o,
  input logic [LEN_W-1:0]  inst_len_o,
  input logic              illegal_o
);
  logic [ADDR_W-1:0] nxt_pc;
  logic              nxt_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_pc <= '0;
      nxt_v  <= 1'b0;
    end else if (flush_i) begin
      nxt_v <= 1'b0;
    end else if (inst_valid_o && inst_ready_i) begin
      nxt_v  <= 1'b1;
      nxt_pc <= inst_pc_o + ADDR_W'(inst_len_o);
    end
  end

  // R1
  kind_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid_o |-> (inst_compressed_o == (inst_o[1:0] != 2'b11)) &&
                     (inst_len_o == (inst_compressed_o ? LEN_W'(2) : LEN_W'(4))));
  // R1
  short_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid_o && inst_compressed_o) |-> (inst_o[ILEN-1:HALF_W] == '0));
  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid_o && nxt_v) |-> (inst_pc_o == nxt_pc));
  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready_o |-> (fetch_addr_o[1:0] == 2'b00));
  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!fetch_ready_o && !inst_valid_o));
  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!inst_valid_o && !illegal_o));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid_o && !inst_ready_i && !flush_i) |=>
      (inst_valid_o && $stable(inst_o) && $stable(inst_pc_o) && $stable(inst_compressed_o)));
  // R9
  stall_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid_o && !inst_ready_i) |-> !fetch_ready_o);
endmodule

bind fetch_aligner fa_checker #(.ADDR_W(ADDR_W)) u_fa_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .flush_i          (flush_i),
  .fetch_addr_o     (fetch_addr_o),
  .fetch_ready_o    (fetch_ready_o),
  .inst_valid_o     (inst_valid_o),
  .inst_ready_i     (inst_ready_i),
  .inst_o           (inst_o),
  .inst_pc_o        (inst_pc_o),
  .inst_compressed_o(inst_compressed_o),
  .inst_len_o       (inst_len_o),
  .illegal_o        (illegal_o)
);

// File: tb/test_fetch_aligner.sv
module test_fetch_aligner;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush_i = 1'b0;
  logic [AW-1:0] flush_pc_i = '0;
  logic [AW-1:0] fetch_addr_o;
  logic          fetch_ready_o;
  logic          fetch_valid_i = 1'b0;
  logic [31:0]   fetch_data_i;
  logic          inst_valid_o;
  logic          inst_ready_i = 1'b0;
  logic [31:0]   inst_o;
  logic [AW-1:0] inst_pc_o;
  logic          inst_compressed_o;
  logic [2:0]    inst_len_o;
  logic          illegal_o;

  always #2 clk = ~clk;

  fetch_aligner #(.ADDR_W(AW)) i_fetch_aligner (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_pc_i(flush_pc_i),
    .fetch_addr_o(fetch_addr_o), .fetch_ready_o(fetch_ready_o),
    .fetch_valid_i(fetch_valid_i), .fetch_data_i(fetch_data_i),
    .inst_valid_o(inst_valid_o), .inst_ready_i(inst_ready_i), .inst_o(inst_o),
    .inst_pc_o(inst_pc_o), .inst_compressed_o(inst_compressed_o),
    .inst_len_o(inst_len_o), .illegal_o(illegal_o)
  );

  logic [31:0] mem [0:63];
  assign fetch_data_i = mem[fetch_addr_o[7:2]];

  typedef struct { logic [31:0] inst; logic [AW-1:0] pc; logic cmp; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0, n_fetch = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit fv_en = 0, stall = 0, done = 0;
  logic [AW-1:0] run_start, run_end;

  function automatic logic [15:0] nxt(logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  function automatic logic [15:0] get_half(logic [AW-1:0] a);
    return a[1] ? mem[a[7:2]][31:16] : mem[a[7:2]][15:0];
  endfunction

  task automatic put_half(logic [AW-1:0] a, logic [15:0] h);
    if (a[1]) mem[a[7:2]][31:16] = h;
    else      mem[a[7:2]][15:0]  = h;
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: flush to a start PC and push the expected instruction stream
  task automatic start(logic [AW-1:0] pc);
    logic [AW-1:0] p;
    logic [15:0] h;
    @(negedge clk);
    flush_i = 1'b1;
    flush_pc_i = pc;
    q.delete();
    n_fetch = 0;
    fv_en = 1;
    p = pc;
    for (int i = 0; i < 64; i++) begin
      h = get_half(p);
      if (h == 16'h0000) break;
      if (h[1:0] == 2'b11) begin
        q.push_back('{inst: {get_half(p + 2), h}, pc: p, cmp: 1'b0});
        p = p + 4;
      end else begin
        q.push_back('{inst: {16'h0000, h}, pc: p, cmp: 1'b1});
        p = p + 2;
      end
    end
    run_start = pc;
    run_end = p;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  task automatic finish_run();
    do begin
      @(negedge clk);
      #2;
    end while (!(q.size() == 0 && illegal_o));
    chk(illegal_o == 1'b1, "R7", "illegal flag at zero half", {31'd0, illegal_o}, 32'd1);
    chk(inst_valid_o == 1'b0, "R7", "zero half not issued", {31'd0, inst_valid_o}, 32'd0);
    chk(n_fetch == (run_end >> 2) - (run_start >> 2) + 1, "R6", "fetch count",
        n_fetch, (run_end >> 2) - (run_start >> 2) + 1);
    repeat (3) begin
      @(negedge clk);
      #2;
      chk(!fetch_ready_o && !inst_valid_o && illegal_o, "R7", "halt sticky",
          {29'd0, fetch_ready_o, inst_valid_o, illegal_o}, 32'd1);
    end
  endtask

  // Monitor: handshake stimulus and scoreboard compare
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      lfsr = nxt(lfsr);
      inst_ready_i = !stall && (lfsr[5] || lfsr[9]);
      fetch_valid_i = fv_en && (lfsr[3] || lfsr[11]);
      #1;
      if (rst_n && !flush_i) begin
        if (fetch_ready_o && fetch_valid_i) n_fetch++;
        if (inst_valid_o && inst_ready_i) begin
          if (q.size() == 0) begin
            chk(1'b0, "R5", "unexpected instruction", inst_o, 32'd0);
          end else begin
            e = q.pop_front();
            if (e.cmp)
              chk(inst_o == e.inst, "R2", "compressed instruction", inst_o, e.inst);
            else if (e.pc[1])
              chk(inst_o == e.inst, "R4", "straddling instruction", inst_o, e.inst);
            else
              chk(inst_o == e.inst, "R3", "aligned instruction", inst_o, e.inst);
            chk(inst_pc_o == e.pc, "R5", "instruction pc", inst_pc_o, e.pc);
            chk(inst_compressed_o == e.cmp && inst_len_o == (e.cmp ? 3'd2 : 3'd4), "R1",
                "kind/length", {28'd0, inst_compressed_o, inst_len_o}, {28'd0, e.cmp, e.cmp ? 3'd2 : 3'd4});
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog: actual hung expected run complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] p;
    logic [15:0] r;
    logic [31:0] cap;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;

    // program A at 0x00: mixed, two straddles, held zero half at the end
    put_half(32'h00, 16'h4505); put_half(32'h02, 16'h0093); put_half(32'h04, 16'h0000);
    put_half(32'h06, 16'h8082); put_half(32'h08, 16'h1137); put_half(32'h0A, 16'h1234);
    put_half(32'h0C, 16'h0505); put_half(32'h0E, 16'h0001); put_half(32'h10, 16'h2a23);
    put_half(32'h12, 16'h00b5); put_half(32'h14, 16'h0613); put_half(32'h16, 16'h0640);
    put_half(32'h18, 16'h4681); put_half(32'h1A, 16'h0793); put_half(32'h1C, 16'h0320);
    put_half(32'h1E, 16'h0000);
    // program B at 0x42: low half of word 0x40 must be discarded
    put_half(32'h40, 16'hFFFF); put_half(32'h42, 16'h0513); put_half(32'h44, 16'hABCD);
    put_half(32'h46, 16'h4711); put_half(32'h48, 16'h0000);
    // program C at 0x80: pseudo-random mix
    p = 32'h80;
    r = 16'h1D2B;
    while (p < 32'hCC) begin
      r = nxt(r);
      if (r[0]) begin
        put_half(p, {r[15:2], r[1] ? 2'b10 : 2'b01});
        p = p + 2;
      end else begin
        put_half(p, {r[15:2], 2'b11});
        put_half(p + 2, r[7] ? 16'h0000 : (r ^ 16'h5A5A));
        p = p + 4;
      end
    end
    put_half(p, 16'h0000);

    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    chk(inst_valid_o == 1'b0, "R10", "valid in reset", {31'd0, inst_valid_o}, 32'd0);
    chk(illegal_o == 1'b0, "R10", "illegal in reset", {31'd0, illegal_o}, 32'd0);
    chk(fetch_addr_o == 32'h0, "R10", "fetch address in reset", fetch_addr_o, 32'h0);
    rst_n = 1'b1;

    start(32'h00);
    finish_run();

    start(32'h42);
    #1;
    chk(illegal_o == 1'b0, "R8", "flush clears illegal", {31'd0, illegal_o}, 32'd0);
    finish_run();

    start(32'h80);
    finish_run();

    // R9 stall, then R8 flush of a pending instruction
    stall = 1;
    start(32'h00);
    do begin @(negedge clk); #2; end while (!inst_valid_o);
    cap = inst_o;
    repeat (5) begin
      @(negedge clk);
      #2;
      chk(inst_valid_o && inst_o == cap, "R9", "held instruction", inst_o, cap);
      chk(fetch_ready_o == 1'b0, "R9", "no fetch while stalled", {31'd0, fetch_ready_o}, 32'd0);
    end
    start(32'h42);
    #1;
    chk(inst_valid_o == 1'b0, "R8", "flush drops pending", {31'd0, inst_valid_o}, 32'd0);
    stall = 0;
    finish_run();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule